// File: doc/BRIEF.md
# Repeated String Compare Engine

This block runs a repeated string comparison over a simple synchronous read port. It has two modes. In scan mode it compares a held accumulator value with successive memory elements taken at a destination pointer. In compare mode it compares the element at a source pointer with the element at a destination pointer. The element size is one, two or four bytes. After each comparison the pointers in use move by the element size, either up or down as the direction input selects. The count is decremented once per comparison.

A run ends in one of two ways. Either the count reaches zero, or the comparison result meets the stop condition chosen by the repeat kind: a repeat-while-equal run stops on the first mismatch, and a repeat-while-not-equal run stops on the first match. When the run ends, the engine gives back the final pointers, the remaining count and a zero flag that holds the outcome of the last comparison. A single-cycle done pulse marks the end of the run. Memory reads are issued one at a time, and the engine waits for a read-valid strobe before it uses the data.

Top module: `strcmp_engine`

## Requirements
- R1: After reset, done, mem_req and zf are 0, and count_out, src_ptr_out and dst_ptr_out are all 0.
- R2: A start accepted with count_in equal to 0 issues no memory read. It pulses done in the following cycle, returns the supplied pointers with count_out 0, and leaves zf unchanged.
- R3: In scan mode (cmp_mode 0), each step reads only the destination pointer and compares the value with acc_in. src_ptr_out does not change.
- R4: In compare mode (cmp_mode 1), each step reads the source pointer first and then the destination pointer, compares the two elements, and then moves both pointers.
- R5: The elem_size code gives the pointer step: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes.
- R6: With dir_down 0 the pointers increase by the step. With dir_down 1 they decrease by the step. Both directions wrap modulo 2^ADDR_W.
- R7: Each comparison lowers the count by exactly one, and a run stops after the comparison that brings the count to zero.
- R8: With rep_while_ne 0 a run stops after the first unequal comparison. With rep_while_ne 1 it stops after the first equal comparison.
- R9: zf is 1 when the last comparison found the elements equal and 0 when it found them different.
- R10: Only the low 8, 16 or 32 bits (size code 0, 1, otherwise) of the two operands take part in a comparison. Bits above the element size have no effect on the result.
- R11: done is a one-cycle pulse in the cycle after the final read-valid. A start raised while a run is in progress has no effect on that run.
- R12: mem_req is high for one cycle per read, and no new read is issued until the read-valid for the previous one has arrived. Data arrives on mem_rdata with mem_rvalid, little-endian from mem_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the values on the setup inputs |
| cmp_mode | input | 1 | 0 scan against accumulator, 1 compare two strings |
| elem_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| rep_while_ne | input | 1 | 0 repeat while equal, 1 repeat while not equal |
| dir_down | input | 1 | 0 pointers increase, 1 pointers decrease |
| src_ptr_in | input | ADDR_W | Initial source pointer |
| dst_ptr_in | input | ADDR_W | Initial destination pointer |
| count_in | input | CNT_W | Initial count |
| acc_in | input | 32 | Accumulator value for scan mode |
| mem_req | output | 1 | Read request strobe |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, byte at mem_addr in bits 7:0 |
| src_ptr_out | output | ADDR_W | Current/final source pointer |
| dst_ptr_out | output | ADDR_W | Current/final destination pointer |
| count_out | output | CNT_W | Current/final count |
| zf | output | 1 | Result of the last comparison |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench covers scan runs and compare runs with each element size, in both directions. One run uses an accumulator whose upper bits are garbage, which shows whether masking works. One run ends on a mismatch under repeat-while-equal, and another ends on a match under repeat-while-not-equal; these tell a data-dependent stop apart from exhaustion of the count. Exhausting runs, a single-step run, a run whose pointer crosses address zero, and zero-count starts issued both after reset and after a run that left the flag set separate the count logic, the wrap arithmetic and flag retention. Read latencies are varied, and a stray start is injected during a run, to show that the handshake waits correctly and that a busy engine ignores start.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    localparam int ELEM_W  = 32;
    localparam int LANES   = ELEM_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_SRC,
        ST_WAIT_SRC,
        ST_REQ_DST,
        ST_WAIT_DST
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic       cmp_mode;
        logic [1:0] size;
        logic       rep_ne;
        logic       dir_down;
    } run_cfg_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] size);
        case (elem_size_e'(size))
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lanes_used(input logic [1:0] size);
        case (elem_size_e'(size))
            SZ_BYTE: return 4'b0001;
            SZ_WORD: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/strcmp_ptr_step.sv
module strcmp_ptr_step
    import strcmp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [1:0]        size,
    input  logic              dir_down,
    output logic [ADDR_W-1:0] ptr_next
);
    localparam int PAD_W = ADDR_W - 3;

    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta    = {{PAD_W{1'b0}}, step_bytes(size)};
        ptr_next = dir_down ? (ptr - delta) : (ptr + delta);
    end
endmodule

// File: rtl/strcmp_elem_cmp.sv
module strcmp_elem_cmp
    import strcmp_pkg::*;
(
    input  logic [ELEM_W-1:0] lhs,
    input  logic [ELEM_W-1:0] rhs,
    input  logic [1:0]        size,
    output logic              equal
);
    logic [LANES-1:0] lane_eq;
    logic [LANES-1:0] lane_on;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (lhs[g*8 +: 8] == rhs[g*8 +: 8]);
    end

    always_comb begin
        lane_on = lanes_used(size);
        equal   = &(lane_eq | ~lane_on);
    end
endmodule

// File: rtl/strcmp_ctrl.sv
module strcmp_ctrl
    import strcmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_cmp,
    input  logic start_cnt_zero,
    input  logic cfg_cmp,
    input  logic mem_rvalid,
    input  logic stop_now,
    output logic load,
    output logic src_cap,
    output logic step,
    output logic mem_req,
    output logic sel_dst,
    output logic idle,
    output logic done
);
    seq_state_e st_q, st_d;
    logic       done_d;

    always_comb begin
        st_d    = st_q;
        load    = 1'b0;
        src_cap = 1'b0;
        step    = 1'b0;
        mem_req = 1'b0;
        sel_dst = 1'b0;
        done_d  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (start_cnt_zero) begin
                        done_d = 1'b1;
                    end else begin
                        st_d = start_cmp ? ST_REQ_SRC : ST_REQ_DST;
                    end
                end
            end
            ST_REQ_SRC: begin
                mem_req = 1'b1;
                st_d    = ST_WAIT_SRC;
            end
            ST_WAIT_SRC: begin
                if (mem_rvalid) begin
                    src_cap = 1'b1;
                    st_d    = ST_REQ_DST;
                end
            end
            ST_REQ_DST: begin
                mem_req = 1'b1;
                sel_dst = 1'b1;
                st_d    = ST_WAIT_DST;
            end
            ST_WAIT_DST: begin
                sel_dst = 1'b1;
                if (mem_rvalid) begin
                    step = 1'b1;
                    if (stop_now) begin
                        done_d = 1'b1;
                        st_d   = ST_IDLE;
                    end else begin
                        st_d = cfg_cmp ? ST_REQ_SRC : ST_REQ_DST;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st_q <= st_d;
            done <= done_d;
        end
    end

    assign idle = (st_q == ST_IDLE);
endmodule

// File: rtl/strcmp_engine.sv
module strcmp_engine
    import strcmp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmp_mode,
    input  logic [1:0]        elem_size,
    input  logic              rep_while_ne,
    input  logic              dir_down,
    input  logic [ADDR_W-1:0] src_ptr_in,
    input  logic [ADDR_W-1:0] dst_ptr_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [ELEM_W-1:0] acc_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] src_ptr_out,
    output logic [ADDR_W-1:0] dst_ptr_out,
    output logic [CNT_W-1:0]  count_out,
    output logic              zf,
    output logic              done
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    run_cfg_t          cfg_q;
    logic [ADDR_W-1:0] src_q, dst_q, src_nx, dst_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [ELEM_W-1:0] acc_q, opnd_q, lhs;
    logic              zf_q;
    logic              elem_eq, stop_now;
    logic              load, src_cap, step_en, sel_dst, ctrl_idle;

    strcmp_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .start_cmp      (cmp_mode),
        .start_cnt_zero (count_in == '0),
        .cfg_cmp        (cfg_q.cmp_mode),
        .mem_rvalid     (mem_rvalid),
        .stop_now       (stop_now),
        .load           (load),
        .src_cap        (src_cap),
        .step           (step_en),
        .mem_req        (mem_req),
        .sel_dst        (sel_dst),
        .idle           (ctrl_idle),
        .done           (done)
    );

    strcmp_ptr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .ptr      (src_q),
        .size     (cfg_q.size),
        .dir_down (cfg_q.dir_down),
        .ptr_next (src_nx)
    );

    strcmp_ptr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .ptr      (dst_q),
        .size     (cfg_q.size),
        .dir_down (cfg_q.dir_down),
        .ptr_next (dst_nx)
    );

    assign lhs = cfg_q.cmp_mode ? opnd_q : acc_q;

    strcmp_elem_cmp u_cmp (
        .lhs   (lhs),
        .rhs   (mem_rdata),
        .size  (cfg_q.size),
        .equal (elem_eq)
    );

    assign stop_now = (cnt_q == CNT_ONE) || (cfg_q.rep_ne ? elem_eq : !elem_eq);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            acc_q  <= '0;
            opnd_q <= '0;
            zf_q   <= 1'b0;
        end else begin
            if (load) begin
                cfg_q.cmp_mode <= cmp_mode;
                cfg_q.size     <= elem_size;
                cfg_q.rep_ne   <= rep_while_ne;
                cfg_q.dir_down <= dir_down;
                src_q          <= src_ptr_in;
                dst_q          <= dst_ptr_in;
                cnt_q          <= count_in;
                acc_q          <= acc_in;
            end
            if (src_cap) begin
                opnd_q <= mem_rdata;
            end
            if (step_en) begin
                zf_q  <= elem_eq;
                dst_q <= dst_nx;
                cnt_q <= cnt_q - CNT_ONE;
                if (cfg_q.cmp_mode) begin
                    src_q <= src_nx;
                end
            end
        end
    end

    assign mem_addr    = sel_dst ? dst_q : src_q;
    assign src_ptr_out = src_q;
    assign dst_ptr_out = dst_q;
    assign count_out   = cnt_q;
    assign zf          = zf_q;
endmodule

// File: rtl/strcmp_engine_chk.sv
module strcmp_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  count_in,
    input logic              mem_req,
    input logic              done,
    input logic              zf,
    input logic [CNT_W-1:0]  count_out,
    input logic [ADDR_W-1:0] src_ptr_out,
    input logic [ADDR_W-1:0] dst_ptr_out,
    input logic              idle,
    input logic              step,
    input logic              cmp_on,
    input logic              rep_ne
);
    // R12
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && start && count_in == '0) |=> (done && !mem_req && $stable(zf)));

    // R7
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (count_out == $past(count_out) - CNT_W'(1)));

    // R3
    scan_src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !cmp_on) |=> $stable(src_ptr_out));

    // R6
    dst_moves_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (dst_ptr_out != $past(dst_ptr_out)));

    // R8
    early_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (done && count_out != '0) |-> (zf == rep_ne));
endmodule

bind strcmp_engine strcmp_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .count_in    (count_in),
    .mem_req     (mem_req),
    .done        (done),
    .zf          (zf),
    .count_out   (count_out),
    .src_ptr_out (src_ptr_out),
    .dst_ptr_out (dst_ptr_out),
    .idle        (ctrl_idle),
    .step        (step_en),
    .cmp_on      (cfg_q.cmp_mode),
    .rep_ne      (cfg_q.rep_ne)
);

// File: tb/strcmp_engine_bench.sv
module strcmp_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, cmp_mode = 1'b0, rep_while_ne = 1'b0, dir_down = 1'b0;
    logic [1:0]  elem_size = 2'd0;
    logic [15:0] src_ptr_in = '0, dst_ptr_in = '0, count_in = '0;
    logic [31:0] acc_in = '0;
    logic        mem_req, mem_rvalid = 1'b0, zf, done;
    logic [15:0] mem_addr, src_ptr_out, dst_ptr_out, count_out;
    logic [31:0] mem_rdata = '0;

    int checks = 0, errors = 0, cyc = 0, mem_lat = 1;
    string cur_tag = "";

    logic [7:0]  mem [0:255];
    logic [15:0] addr_q [$];
    logic [15:0] exp_src, exp_dst, exp_cnt, rsp_addr;
    logic        m_zf, m_busy, done_due;
    int          exp_total, served, rsp_cnt;

    always #10 clk = ~clk;

    strcmp_engine u_strcmp_engine (
        .clk(clk), .rst(rst), .start(start), .cmp_mode(cmp_mode),
        .elem_size(elem_size), .rep_while_ne(rep_while_ne), .dir_down(dir_down),
        .src_ptr_in(src_ptr_in), .dst_ptr_in(dst_ptr_in), .count_in(count_in),
        .acc_in(acc_in), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .src_ptr_out(src_ptr_out),
        .dst_ptr_out(dst_ptr_out), .count_out(count_out), .zf(zf), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fetch(input logic [15:0] a);
        logic [7:0] i;
        i = a[7:0];
        return {mem[i + 8'd3], mem[i + 8'd2], mem[i + 8'd1], mem[i]};
    endfunction

    function automatic logic [31:0] msk(input logic [1:0] s);
        return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    // behavioural model of a whole run, evaluated when start is accepted
    task automatic model_start();
        logic [15:0] s, d, c, st;
        logic [31:0] a, b;
        bit eq;
        s = src_ptr_in; d = dst_ptr_in; c = count_in;
        st = (elem_size == 2'd0) ? 16'd1 : (elem_size == 2'd1) ? 16'd2 : 16'd4;
        addr_q.delete();
        while (c != 0) begin
            if (cmp_mode) begin
                addr_q.push_back(s);
                a = fetch(s);
            end else begin
                a = acc_in;
            end
            addr_q.push_back(d);
            b = fetch(d);
            eq = ((a & msk(elem_size)) == (b & msk(elem_size)));
            m_zf = eq;
            d = dir_down ? d - st : d + st;
            if (cmp_mode) s = dir_down ? s - st : s + st;
            c = c - 16'd1;
            if (rep_while_ne ? eq : !eq) break;
        end
        exp_src = s; exp_dst = d; exp_cnt = c;
        exp_total = addr_q.size();
        served = 0;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mem_rvalid = 1'b0; rsp_cnt = 0; m_busy = 1'b0; m_zf = 1'b0;
            done_due = 1'b0; addr_q.delete(); served = 0; exp_total = 0;
        end else begin
            chk(done === done_due, {"R11 done timing ", cur_tag}, {31'd0, done}, {31'd0, done_due});
            if (done_due) begin
                chk(src_ptr_out === exp_src, {"R4/R6 src final ", cur_tag}, {16'd0, src_ptr_out}, {16'd0, exp_src});
                chk(dst_ptr_out === exp_dst, {"R5/R6 dst final ", cur_tag}, {16'd0, dst_ptr_out}, {16'd0, dst_ptr_out == exp_dst ? dst_ptr_out : exp_dst});
                chk(count_out === exp_cnt, {"R7/R8 count final ", cur_tag}, {16'd0, count_out}, {16'd0, exp_cnt});
                chk(zf === m_zf, {"R9/R10 zf final ", cur_tag}, {31'd0, zf}, {31'd0, m_zf});
                chk(addr_q.size() == 0, {"R3/R4 reads missing ", cur_tag}, addr_q.size(), 0);
                m_busy = 1'b0;
            end
            done_due = 1'b0;
            mem_rvalid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = fetch(rsp_addr);
                    served++;
                    if (served == exp_total) done_due = 1'b1;
                end
            end
            if (mem_req) begin
                chk(rsp_cnt == 0, {"R12 read while outstanding ", cur_tag}, rsp_cnt, 0);
                if (addr_q.size() == 0) begin
                    chk(1'b0, {"R2/R12 unexpected read ", cur_tag}, {16'd0, mem_addr}, 0);
                end else begin
                    logic [15:0] ea;
                    ea = addr_q.pop_front();
                    chk(mem_addr === ea, {"R3/R4/R5/R6 read address ", cur_tag}, {16'd0, mem_addr}, {16'd0, ea});
                end
                rsp_cnt = mem_lat;
                rsp_addr = mem_addr;
            end
            if (start && !m_busy) begin
                model_start();
                m_busy = 1'b1;
                if (exp_total == 0) done_due = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic launch(input bit cm, input logic [1:0] sz, input bit rn, input bit dn,
                          input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                          input logic [31:0] a, input int lat, input string tag);
        @(posedge clk); #2;
        cmp_mode = cm; elem_size = sz; rep_while_ne = rn; dir_down = dn;
        src_ptr_in = s; dst_ptr_in = d; count_in = c; acc_in = a;
        mem_lat = lat; cur_tag = tag; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic finish_run();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk(done === 1'b0 && mem_req === 1'b0 && zf === 1'b0, "R1 reset flags", {29'd0, done, mem_req, zf}, 0);
        chk(count_out === 16'd0 && src_ptr_out === 16'd0 && dst_ptr_out === 16'd0, "R1 reset state",
            {count_out, src_ptr_out | dst_ptr_out}, 0);

        // R2 zero count right after reset
        launch(1'b1, 2'd2, 1'b0, 1'b0, 16'h1234, 16'h5678, 16'd0, 32'h0, 1, "R2 zero count after reset");
        finish_run();

        // R3 R8 R10 scan byte while-equal, upper accumulator bits ignored
        for (int i = 16; i < 24; i++) mem[i] = 8'h41;
        mem[8'h14] = 8'h42;
        launch(1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0010, 16'd8, 32'hABCD_EF41, 1, "R3 R8 R10 scan byte while-equal");
        finish_run();

        // R5 R6 R8 R10 scan word while-not-equal downward
        for (int i = 8'h20; i < 8'h50; i++) mem[i] = 8'h11;
        mem[8'h38] = 8'h5A; mem[8'h39] = 8'h3C;
        launch(1'b0, 2'd1, 1'b1, 1'b1, 16'h0000, 16'h0040, 16'd10, 32'h7777_3C5A, 2, "R5 R6 R8 R10 scan word while-not-equal down");
        finish_run();

        // R4 R7 R9 compare dword exhausting count
        for (int i = 0; i < 16; i++) begin
            mem[8'h80 + i] = 8'(i * 13 + 1);
            mem[8'hC0 + i] = 8'(i * 13 + 1);
        end
        launch(1'b1, 2'd2, 1'b0, 1'b0, 16'h0080, 16'h00C0, 16'd4, 32'h0, 3, "R4 R7 R9 compare dword exhaust");
        finish_run();

        // R2 zero count keeps flag set by the previous run
        launch(1'b0, 2'd0, 1'b1, 1'b1, 16'h0F0F, 16'h0E0E, 16'd0, 32'h0, 1, "R2 zero count keeps flag");
        finish_run();

        // R4 R6 R8 compare byte while-not-equal downward
        for (int i = 8'h9A; i <= 8'h9F; i++) begin
            mem[i] = 8'(i);
            mem[i + 8'h40] = 8'(i + 1);
        end
        mem[8'hDB] = mem[8'h9B];
        launch(1'b1, 2'd0, 1'b1, 1'b1, 16'h009F, 16'h00DF, 16'd6, 32'h0, 1, "R4 R6 R8 compare byte while-not-equal down");
        finish_run();

        // R6 R7 downward pointer wraps through address zero
        mem[0] = 0; mem[1] = 0; mem[2] = 0; mem[3] = 0; mem[8'hFE] = 0; mem[8'hFF] = 0;
        launch(1'b0, 2'd1, 1'b0, 1'b1, 16'h0000, 16'h0002, 16'd3, 32'hFFFF_0000, 2, "R6 R7 pointer wraps");
        finish_run();

        // R7 R9 single step with mismatch
        launch(1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 16'h0060, 16'd1, 32'hDEAD_BEEF, 1, "R7 R9 single step");
        finish_run();

        // R5 size code 3 steps by four
        launch(1'b1, 2'd3, 1'b0, 1'b0, 16'h0080, 16'h00C0, 16'd3, 32'h0, 1, "R5 size code 3");
        finish_run();

        // R11 start ignored while busy
        launch(1'b1, 2'd2, 1'b0, 1'b0, 16'h0080, 16'h00C0, 16'd4, 32'h0, 3, "R11 start ignored while busy");
        repeat (4) @(posedge clk); #2;
        cmp_mode = 1'b0; elem_size = 2'd0; dir_down = 1'b1; count_in = 16'd0;
        src_ptr_in = 16'hAAAA; dst_ptr_in = 16'h5555; start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        finish_run();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule